// File: doc/BRIEF.md
# Eight-Channel Compare Timer Bank

This block holds eight compare channels, numbered 4 to 11. Each channel has a 32-bit count register, a 32-bit compare value and a control word. The control word picks which rate tick advances the count. It also sets whether the count returns to zero on a hit, and whether the channel fires on every hit or only once. Channels 5, 6, 7, 9 and 11 can either keep their own count or borrow the count of a group leader: channel 4 leads 5 to 7, channel 8 leads 9, and channel 10 leads 11. A hit on a channel whose enable bit is set latches a status bit. A single interrupt line stays high while any latched status bit remains.

Rate ticks come in as single-cycle enables from a prescaler outside the block. Software reaches the block through a simple register port: a write strobe, a read strobe, a byte address and 32-bit data. Read data is combinational from the address. Reading the count of channel 9 or 11 can also freeze the count of the channel before it into a snapshot register, so that two counters can be sampled together.

Top module: `tmr_match_bank`

## Requirements
- R1: Control bits [2:0] select the tick that advances a channel's count by one: 1 uses tick_en[0] (32.768 kHz), 2 uses tick_en[1] (1 kHz), 3 uses tick_en[2] (1 Hz), 4 uses tick_en[3] (1 MHz) and 5 uses tick_en[4] (external). Codes 0, 6 and 7 hold the count.
- R2: Control writes keep bits [7:0] on channels 4–7 and bits [9:0] on channels 8–11, with the other bits read back as zero. On channels 8–11, bit 8 set holds the count whatever the select code is.
- R3: On channels 5, 6, 7, 9 and 11, with control bit 7 clear, the channel's own count holds and its compare uses the leader's count (4, 4, 4, 8, 10). With bit 7 set, the channel uses its own count. Channels 4, 8 and 10 always use their own count.
- R4: A hit on a channel happens in the cycle where its reference count advances to a value equal to its compare register.
- R5: With control bit 3 set, a hit loads the channel's own count with zero instead of the advanced value.
- R6: With control bit 6 set, the channel is periodic and every hit counts. With it clear, the channel is one-shot: after one hit it ignores further hits until its compare or control register is written.
- R7: A hit on channel k with enable bit k set sets status bit k. Writing 1 to a status bit clears it. A new hit in the same cycle wins over the clear.
- R8: The irq output is high exactly when at least one status bit is set.
- R9: Reading channel 9's count while its control bit 9 is set copies channel 8's count into the snapshot register. The same holds for channel 11 and channel 10. Other reads leave the snapshot unchanged.
- R10: After reset every count, compare, control, status, enable and snapshot bit reads as zero, and irq is low.
- R11: The map is: counts at 0x40+4·(k−4), compare values at 0x80+4·(k−4), controls at 0xC0+4·(k−4), status at 0x14 and enables at 0x1C (both on bits 4–11 for channels 4–11), and the snapshot at 0x20. Writes take effect at the next clock edge. Reads of any other address return zero and writes to them do nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (starts a snapshot capture) |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick_en | input | 5 | Single-cycle rate ticks: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq | output | 1 | Combined channel interrupt |

## Verification
Every stored result is settled at the one clock edge that ends the cycle holding the stimulus. This covers count steps, hits, status and irq, and snapshot captures. Read data reflects the current state within the same cycle.

The bench therefore sets its inputs after a falling edge and checks rdata just after that, against its model's current state. It then lets the rising edge pass and steps its model once. At the next falling edge it compares irq, so every comparison lands exactly one register stage after its cause.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  localparam int NCH       = 8;   // channels 4..11 as indices 0..7
  localparam int NTICK     = 5;   // rate tick inputs
  localparam int CTL_W     = 10;  // stored control width
  localparam int NARROW_CH = 4;   // indices below this keep 8 control bits
  localparam int NARROW_W  = 8;
  localparam int ST_LSB    = 4;   // status/enable bit of channel index 0

  // control bit positions
  localparam int CB_RST  = 3;
  localparam int CB_PER  = 6;
  localparam int CB_OWN  = 7;
  localparam int CB_OFF  = 8;
  localparam int CB_SNAP = 9;

  // group leader of a channel index
  function automatic int lead_of(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_bank_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_we,
  input  logic             mat_we,
  input  logic             ctl_we,
  input  logic [DW-1:0]    wdata,
  input  logic [NTICK-1:0] tick_en,
  input  logic             ref_adv_i,
  input  logic [DW-1:0]    ref_inc_i,
  output logic             own_adv_o,
  output logic [DW-1:0]    own_inc_o,
  output logic [DW-1:0]    cnt_o,
  output logic [DW-1:0]    mat_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             evt_o
);
  localparam bit IS_LEAD = (lead_of(IDX) == IDX);
  localparam bit WIDE    = (IDX >= NARROW_CH);
  localparam int KEEP_W  = WIDE ? CTL_W : NARROW_W;
  localparam logic [CTL_W-1:0] KEEP = CTL_W'((1 << KEEP_W) - 1);

  logic [DW-1:0]    cnt_q, cnt_d, mat_q, mat_d, own_inc, ref_inc;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             arm_q, arm_d;
  logic             sel_tick, clk_off, use_own, own_adv, ref_adv, evt;

  // tick selection
  always_comb begin
    sel_tick = 1'b0;
    for (int j = 0; j < NTICK; j++) begin
      if (ctl_q[2:0] == 3'(j + 1)) sel_tick = tick_en[j];
    end
  end

  // reference count and hit detection
  always_comb begin
    clk_off = WIDE && ctl_q[CB_OFF];
    use_own = IS_LEAD || ctl_q[CB_OWN];
    own_adv = use_own && sel_tick && !clk_off && !cnt_we;
    own_inc = cnt_q + DW'(1);
    ref_adv = use_own ? own_adv : ref_adv_i;
    ref_inc = use_own ? own_inc : ref_inc_i;
    evt     = ref_adv && (ref_inc == mat_q) && (ctl_q[CB_PER] || arm_q);
  end

  // next state
  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we)                      cnt_d = wdata;
    else if (evt && ctl_q[CB_RST])   cnt_d = '0;
    else if (own_adv)                cnt_d = own_inc;
    mat_d = mat_we ? wdata : mat_q;
    ctl_d = ctl_we ? (wdata[CTL_W-1:0] & KEEP) : ctl_q;
    arm_d = arm_q;
    if (mat_we || ctl_we) arm_d = 1'b1;
    else if (evt)         arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mat_q <= '0;
      ctl_q <= '0;
      arm_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      mat_q <= mat_d;
      ctl_q <= ctl_d;
      arm_q <= arm_d;
    end
  end

  assign own_adv_o = own_adv;
  assign own_inc_o = own_inc;
  assign cnt_o     = cnt_q;
  assign mat_o     = mat_q;
  assign ctl_o     = ctl_q;
  assign evt_o     = evt;

  // R5: a clearing hit leaves the count at zero
  p_clear_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctl_q[CB_RST] && !cnt_we) |=> (cnt_q == '0));

  // R6: a one-shot hit is not followed by another without a rewrite
  p_oneshot_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !ctl_q[CB_PER] && !mat_we && !ctl_we) |=> !evt_o);

  // R1: invalid select codes hold the count
  p_stopped_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_q[2:0] == 3'd0 || ctl_q[2:0] > 3'd5) && !cnt_we && !(evt && ctl_q[CB_RST]))
      |=> $stable(cnt_q));

  generate
    if (!IS_LEAD) begin : g_follow_chk
      // R3: a following channel's own count does not move
      p_follow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[CB_OWN] && !cnt_we && !(evt && ctl_q[CB_RST])) |=> $stable(cnt_q));
    end
    if (WIDE) begin : g_off_chk
      // R2: force-off holds the count on wide channels
      p_force_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CB_OFF] && !cnt_we && !(evt && ctl_q[CB_RST])) |=> $stable(cnt_q));
    end
  endgenerate
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_i,
  input  logic           en_we,
  input  logic           clr_we,
  input  logic [NCH-1:0] bits_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] st_o,
  output logic           irq_o
);
  logic [NCH-1:0] st_q, st_d, en_q, en_d, hit;

  always_comb begin
    hit  = evt_i & en_q;
    st_d = (st_q & ~(clr_we ? bits_i : '0)) | hit;
    en_d = en_we ? bits_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = |st_q;

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_st_chk
      // R7: an enabled hit latches its bit even against a clear
      p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[k] && en_q[k]) |=> st_q[k]);
      // R7: a clear with no new hit drops the bit
      p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && bits_i[k] && !(evt_i[k] && en_q[k])) |=> !st_q[k]);
    end
  endgenerate

  // R8: any enabled hit raises the interrupt on the next cycle
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & en_q)) |=> irq_o);
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap #(
  parameter int DW    = 32,
  parameter int NPAIR = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPAIR-1:0]          cap_i,
  input  logic [NPAIR-1:0][DW-1:0]  src_i,
  output logic [DW-1:0]             snap_o
);
  logic [DW-1:0] snap_q, snap_d;

  always_comb begin
    snap_d = snap_q;
    for (int k = NPAIR - 1; k >= 0; k--) begin
      if (cap_i[k]) snap_d = src_i[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign snap_o = snap_q;

  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_snap_chk
      // R9: a capture takes the partner's count of that cycle
      p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i[k] && $onehot0(cap_i)) |=> (snap_o == $past(src_i[k])));
    end
  endgenerate

  // R9: no capture, no change
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i == '0) |=> $stable(snap_o));
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank
  import tmr_bank_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NTICK-1:0] tick_en,
  output logic             irq
);
  localparam int IW = $clog2(NCH);
  localparam int RW = AW - IW - 2;          // region field width
  localparam logic [AW-1:0] CNT_BASE  = AW'('h40);
  localparam logic [AW-1:0] MAT_BASE  = AW'('h80);
  localparam logic [AW-1:0] CTL_BASE  = AW'('hC0);
  localparam logic [AW-1:0] ST_ADDR   = AW'('h14);
  localparam logic [AW-1:0] EN_ADDR   = AW'('h1C);
  localparam logic [AW-1:0] SNAP_ADDR = AW'('h20);
  localparam int SNAP_A = 5, SNAP_B = 7;    // channels 9 and 11

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // address decode
  logic [IW-1:0] idx;
  logic          aligned, cnt_hit, mat_hit, ctl_hit;
  always_comb begin
    idx     = addr[IW+1:2];
    aligned = (addr[1:0] == 2'b00);
    cnt_hit = aligned && (addr[AW-1:IW+2] == CNT_BASE[AW-1:IW+2]);
    mat_hit = aligned && (addr[AW-1:IW+2] == MAT_BASE[AW-1:IW+2]);
    ctl_hit = aligned && (addr[AW-1:IW+2] == CTL_BASE[AW-1:IW+2]);
  end

  logic [NCH-1:0][DW-1:0]    cnt_a, mat_a, inc_a;
  logic [NCH-1:0][CTL_W-1:0] ctl_a;
  logic [NCH-1:0]            adv_a, evt_a;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int LD = lead_of(i);
      logic cwe, mwe, kwe;
      assign cwe = wr_en && cnt_hit && (idx == IW'(i));
      assign mwe = wr_en && mat_hit && (idx == IW'(i));
      assign kwe = wr_en && ctl_hit && (idx == IW'(i));
      tmr_chan #(.DW(DW), .IDX(i)) u_chan (
        .clk       (clk),
        .rst_n     (rst_q),
        .cnt_we    (cwe),
        .mat_we    (mwe),
        .ctl_we    (kwe),
        .wdata     (wdata),
        .tick_en   (tick_en),
        .ref_adv_i (adv_a[LD]),
        .ref_inc_i (inc_a[LD]),
        .own_adv_o (adv_a[i]),
        .own_inc_o (inc_a[i]),
        .cnt_o     (cnt_a[i]),
        .mat_o     (mat_a[i]),
        .ctl_o     (ctl_a[i]),
        .evt_o     (evt_a[i])
      );
    end
  endgenerate

  logic [NCH-1:0] en_v, st_v;
  tmr_status #(.NCH(NCH)) u_status (
    .clk    (clk),
    .rst_n  (rst_q),
    .evt_i  (evt_a),
    .en_we  (wr_en && (addr == EN_ADDR)),
    .clr_we (wr_en && (addr == ST_ADDR)),
    .bits_i (wdata[ST_LSB +: NCH]),
    .en_o   (en_v),
    .st_o   (st_v),
    .irq_o  (irq)
  );

  logic [1:0]         cap;
  logic [1:0][DW-1:0] cap_src;
  logic [DW-1:0]      snap;
  always_comb begin
    cap[0]     = rd_en && cnt_hit && (idx == IW'(SNAP_A)) && ctl_a[SNAP_A][CB_SNAP];
    cap[1]     = rd_en && cnt_hit && (idx == IW'(SNAP_B)) && ctl_a[SNAP_B][CB_SNAP];
    cap_src[0] = cnt_a[SNAP_A-1];
    cap_src[1] = cnt_a[SNAP_B-1];
  end

  tmr_snap #(.DW(DW), .NPAIR(2)) u_snap (
    .clk    (clk),
    .rst_n  (rst_q),
    .cap_i  (cap),
    .src_i  (cap_src),
    .snap_o (snap)
  );

  // read mux
  always_comb begin
    rdata = '0;
    if (cnt_hit)                rdata = cnt_a[idx];
    else if (mat_hit)           rdata = mat_a[idx];
    else if (ctl_hit)           rdata = DW'(ctl_a[idx]);
    else if (addr == ST_ADDR)   rdata = DW'(st_v) << ST_LSB;
    else if (addr == EN_ADDR)   rdata = DW'(en_v) << ST_LSB;
    else if (addr == SNAP_ADDR) rdata = snap;
  end

  // R2: narrow channels never hold the upper control bits
  p_ctl_mask_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && ctl_hit && (idx < IW'(NARROW_CH)))
      |=> (ctl_a[$past(idx)][CTL_W-1:NARROW_W] == '0));

  // R10: interrupt low straight after the reset release
  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> !irq);
endmodule

// File: tb/tmr_match_bank_tb.sv
module tmr_match_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tick_en = '0;
  logic        irq;

  always #2.5 clk = ~clk;   // 200 MHz

  tmr_match_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R10";

  // behavioural reference state
  logic [31:0] m_cnt [8];
  logic [31:0] m_mat [8];
  logic [9:0]  m_ctl [8];
  bit          m_arm [8];
  logic [7:0]  m_st, m_en;
  logic [31:0] m_snap;

  function automatic int leader(int i);
    return (i < 4) ? 0 : ((i < 6) ? 4 : 6);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int k = int'(a[4:2]);
    if (a[1:0] != 2'b00)        return 32'h0;
    if (a >= 8'h40 && a < 8'h60) return m_cnt[k];
    if (a >= 8'h80 && a < 8'hA0) return m_mat[k];
    if (a >= 8'hC0 && a < 8'hE0) return {22'h0, m_ctl[k]};
    if (a == 8'h14)             return {20'h0, m_st, 4'h0};
    if (a == 8'h1C)             return {20'h0, m_en, 4'h0};
    if (a == 8'h20)             return m_snap;
    return 32'h0;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin
      m_cnt[i] = '0; m_mat[i] = '0; m_ctl[i] = '0; m_arm[i] = 1;
    end
    m_st = '0; m_en = '0; m_snap = '0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs are already driven after a falling edge
  task automatic cyc();
    bit adv [8];
    bit own [8];
    bit ev  [8];
    logic [31:0] n_cnt [8];
    logic [7:0]  n_st;
    #1;
    if (rd_en) check(cur_tag, rdata, m_read(addr), $sformatf("read %h", addr));
    for (int i = 0; i < 8; i++) begin
      logic [2:0] code = m_ctl[i][2:0];
      bit tk = 0;
      bit off = (i >= 4) && m_ctl[i][8];
      bit cw = wr_en && (addr == 8'(8'h40 + 4 * i));
      if (code >= 3'd1 && code <= 3'd5 && !off) tk = tick_en[code - 3'd1];
      own[i] = (leader(i) == i) || m_ctl[i][7];
      adv[i] = own[i] && tk && !cw;
    end
    for (int i = 0; i < 8; i++) begin
      int r = own[i] ? i : leader(i);
      ev[i] = adv[r] && ((m_cnt[r] + 32'd1) == m_mat[i]) && (m_ctl[i][6] || m_arm[i]);
    end
    for (int i = 0; i < 8; i++) begin
      n_cnt[i] = m_cnt[i];
      if (wr_en && addr == 8'(8'h40 + 4 * i)) n_cnt[i] = wdata;
      else if (ev[i] && m_ctl[i][3])          n_cnt[i] = '0;
      else if (adv[i])                        n_cnt[i] = m_cnt[i] + 32'd1;
    end
    n_st = m_st;
    if (wr_en && addr == 8'h14) n_st = n_st & ~wdata[11:4];
    for (int i = 0; i < 8; i++) if (ev[i] && m_en[i]) n_st[i] = 1'b1;
    if (rd_en && addr == 8'h54 && m_ctl[5][9]) m_snap = m_cnt[4];
    if (rd_en && addr == 8'h5C && m_ctl[7][9]) m_snap = m_cnt[6];
    for (int i = 0; i < 8; i++) begin
      bit mw = wr_en && addr == 8'(8'h80 + 4 * i);
      bit kw = wr_en && addr == 8'(8'hC0 + 4 * i);
      if (mw) m_mat[i] = wdata;
      if (kw) m_ctl[i] = wdata[9:0] & ((i < 4) ? 10'h0FF : 10'h3FF);
      if (mw || kw)  m_arm[i] = 1;
      else if (ev[i]) m_arm[i] = 0;
      m_cnt[i] = n_cnt[i];
    end
    if (wr_en && addr == 8'h1C) m_en = wdata[11:4];
    m_st = n_st;
    @(posedge clk);
    @(negedge clk);
    check("R8", {31'h0, irq}, {31'h0, |m_st}, "irq");
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cur_tag = tag; rd_en = 1; addr = a;
    cyc();
    rd_en = 0;
  endtask

  task automatic ticks(logic [4:0] m, int n);
    for (int k = 0; k < n; k++) begin
      tick_en = m; cyc();
      tick_en = '0; cyc();
    end
  endtask

  // watchdog
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1D2C_3B4A;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) cyc();

    // R10: everything reads zero after reset
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h40 + 4 * i), "R10");
      rd(8'(8'h80 + 4 * i), "R10");
      rd(8'(8'hC0 + 4 * i), "R10");
    end
    rd(8'h14, "R10"); rd(8'h1C, "R10"); rd(8'h20, "R10");

    // R11: map and write timing, unmapped address
    wr(8'h48, 32'h0000_1234); rd(8'h48, "R11");
    wr(8'h88, 32'h0000_ABCD); rd(8'h88, "R11");
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, "R11");

    // R2: control masks
    wr(8'hC0, 32'h0000_03FF); rd(8'hC0, "R2");
    wr(8'hD0, 32'h0000_03FF); rd(8'hD0, "R2");
    wr(8'hC0, 0); wr(8'hD0, 0);

    // R1: select codes
    wr(8'hC0, 1); wr(8'h40, 0);
    ticks(5'b11110, 3); rd(8'h40, "R1");
    ticks(5'b00001, 4); rd(8'h40, "R1");
    wr(8'hC0, 4); ticks(5'b01000, 2); rd(8'h40, "R1");
    wr(8'hC0, 6); ticks(5'b11111, 3); rd(8'h40, "R1");
    wr(8'hC0, 5); ticks(5'b10000, 1); rd(8'h40, "R1");

    // R2: force-off on a wide channel
    wr(8'h50, 0); wr(8'hD0, 32'h0000_0101);
    ticks(5'b00001, 3); rd(8'h50, "R2");

    // R3/R4: channel 5 follows channel 4
    wr(8'hC0, 1); wr(8'h40, 0); wr(8'h1C, 32'h0000_0FF0);
    wr(8'hC4, 0); wr(8'h84, 3); wr(8'h44, 7);
    ticks(5'b00001, 3); rd(8'h44, "R3"); rd(8'h14, "R4");
    wr(8'hC4, 32'h81); ticks(5'b00001, 2); rd(8'h44, "R3");
    wr(8'h14, 32'h0000_0FF0); rd(8'h14, "R7");

    // R5/R6: periodic clearing channel 8
    wr(8'hD0, 32'h49); wr(8'h90, 3); wr(8'h50, 0);
    ticks(5'b00001, 7); rd(8'h50, "R5"); rd(8'h14, "R6");
    wr(8'h14, 32'h0000_0FF0); wr(8'hD0, 0);

    // R6: one-shot channel 10
    wr(8'hD8, 32'h09); wr(8'h98, 2); wr(8'h58, 0);
    ticks(5'b00001, 2); rd(8'h14, "R6");
    wr(8'h14, 32'h0000_0FF0);
    ticks(5'b00001, 2); rd(8'h58, "R6"); rd(8'h14, "R6");
    wr(8'h98, 3); ticks(5'b00001, 1); rd(8'h14, "R6");
    wr(8'h14, 32'h0000_0FF0);

    // R9: snapshot through channel 9 / 11
    wr(8'hD0, 1); wr(8'h50, 32'h0000_0777);
    wr(8'hD4, 32'h200); rd(8'h54, "R9"); rd(8'h20, "R9");
    wr(8'h58, 32'h55); wr(8'hDC, 0); rd(8'h5C, "R9"); rd(8'h20, "R9");
    wr(8'hDC, 32'h200); rd(8'h5C, "R9"); rd(8'h20, "R9");

    // mixed traffic against the model
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] a;
      logic [2:0] idx;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      idx = lf[20:18];
      case (lf[17:15])
        3'd0: a = {3'b010, idx, 2'b00};
        3'd1: a = {3'b100, idx, 2'b00};
        3'd2, 3'd6: a = {3'b110, idx, 2'b00};
        3'd3: a = 8'h14;
        3'd4: a = 8'h1C;
        3'd5: a = lf[3] ? 8'h20 : 8'h04;
        default: a = lf[4] ? 8'h54 : 8'h5C;
      endcase
      tick_en = lf[9:5] & lf[14:10];
      if (lf[2:0] < 3'd2) begin
        wr_en = 1; addr = a;
        case (lf[17:15])
          3'd0, 3'd1: wdata = {28'h0, lf[24:21]};
          3'd2, 3'd6: wdata = {22'h0, lf[30:21]};
          default:    wdata = {20'h0, lf[31:20]};
        endcase
      end else if (lf[2:0] < 3'd5) begin
        rd_en = 1; addr = a;
        cur_tag = (a == 8'h20 || a == 8'h54 || a == 8'h5C) ? "R9" : "R11";
      end
      cyc();
      wr_en = 0; rd_en = 0; tick_en = '0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule